// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

A purely combinational integer ALU for a 32-bit datapath. It takes two operands, a constant shift amount and an 8-bit control word. It returns one result, chosen by operation class. The class can be a two's-complement adder/subtractor, a signed set-less-than compare, a four-function bitwise unit, or a multistage barrel shifter. Two flags go with the result. One is set when the result is zero. The other reports signed overflow for add and subtract.

The control word has four packed fields:

- bits [7:6] pick the class.
- bit [5] picks add or subtract.
- bits [4:2] steer the shifter.
- bits [1:0] pick the bitwise function.

The shifter builds each shift from one conditional stage per power of two. It handles left logical, right logical and right arithmetic shifts. The amount comes either from the constant port or from the low bits of the second operand.

Top module: `alu_multifunc`

## Requirements
- R1: `ctrl[7:6]` selects the class: 00 gives the shifter, 01 gives set-less-than, 10 gives add/subtract, and 11 gives the bitwise unit.
- R2: In class 10 with `ctrl[5]`=0, `result` = `op_a` + `op_b` modulo 2^32.
- R3: In class 10 with `ctrl[5]`=1, `result` = `op_a` - `op_b` modulo 2^32, formed as `op_a` + ~`op_b` + 1.
- R4: In class 11, `ctrl[1:0]` picks the bitwise function: 00 gives AND, 01 gives OR, 10 gives XOR, 11 gives NOR.
- R5: In class 00 with `ctrl[4]`=0, `result` = `op_a` shifted left with zero fill, and `ctrl[3]` has no effect. The amount is `shamt` when `ctrl[2]`=0, or `op_b[4:0]` when `ctrl[2]`=1. An amount of 0 passes `op_a` through unchanged.
- R6: In class 00 with `ctrl[4]`=1, `op_a` is shifted right by the amount chosen as in R5. The vacated bits are filled with `op_a[31]` when `ctrl[3]`=1 (arithmetic) and with zeros when `ctrl[3]`=0 (logical).
- R7: In class 01, `result` is 1 when `op_a` < `op_b` as signed 32-bit values and 0 otherwise. This holds even when `op_a` - `op_b` overflows.
- R8: `ovf` is 1 only in class 10, and only when the signed add or subtract overflows. In every other class it is 0.
- R9: `zero` is 1 exactly when `result` is all zeros, in every class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; also the value that is shifted |
| op_b | input | 32 | Second operand; its low 5 bits can supply the shift amount |
| shamt | input | 5 | Constant shift amount |
| ctrl | input | 8 | Control word: class, add/subtract, shift control, bitwise function |
| result | output | 32 | Selected result |
| zero | output | 1 | High when `result` is zero |
| ovf | output | 1 | Signed overflow of the add/subtract class |

## Verification
All three outputs are combinational, so each one is due in the same cycle as the stimulus that produces it. The driver applies operands and control just after a rising edge and queues the expected result and flags. The monitor removes the queued item on the following falling edge, half a period later, when the inputs have been stable long enough to settle. Because each stimulus has exactly one queued item and is compared within its own cycle, a late or wrong value cannot shift onto a neighbouring check.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } alu_class_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOR = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic dir_right;
        logic arith;
        logic use_var;
    } shift_ctrl_t;

    typedef struct packed {
        alu_class_e  cls;
        logic        sub;
        shift_ctrl_t sh;
        logic_op_e   lop;
    } alu_ctrl_t;

    localparam int CTRL_W = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             carry;

    assign b_eff        = b ^ {WIDTH{sub}};
    assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    assign ovf          = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

    logic unused_carry;
    assign unused_carry = carry;

    always_comb begin
        AST_SUB_SELF_ZERO: assert (!(sub && (a == b)) || (sum == '0)); // R3
        AST_OVF_SIGNS: assert (!ovf || ((a[MSB] == b[MSB]) != sub));   // R8
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_op_e        op,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (op)
            LOP_AND: y = a & b;
            LOP_OR:  y = a | b;
            LOP_XOR: y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

    always_comb begin
        AST_NOR_DISJOINT: assert (op != LOP_NOR || ((y & a) == '0)); // R4
    end

endmodule

// File: rtl/alu_barrel.sv
module alu_barrel
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  logic             dir_right,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    localparam int MSB = WIDTH - 1;

    logic [SHW:0][WIDTH-1:0] stg;
    logic [WIDTH-1:0]        oriented;
    logic                    fill;

    assign fill = dir_right & arith & din[MSB];

    // A left shift is a right shift of the bit-reversed word, reversed back.
    for (genvar i = 0; i < WIDTH; i++) begin : g_orient
        assign oriented[i] = dir_right ? din[i] : din[MSB-i];
        assign dout[i]     = dir_right ? stg[SHW][i] : stg[SHW][MSB-i];
    end

    assign stg[0] = oriented;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][MSB:STEP]} : stg[k];
    end

    always_comb begin
        AST_SHIFT_NONE: assert (amt != '0 || dout == din);                        // R5
        AST_SIGN_FILL: assert (!(dir_right && arith && din[MSB]) || dout[MSB]);   // R6
        AST_LOGIC_FILL: assert (!(dir_right && !arith && amt != '0) || !dout[MSB]); // R6
    end

endmodule

// File: rtl/alu_multifunc.sv
module alu_multifunc
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [SHW-1:0]    shamt,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [WIDTH-1:0]  result,
    output logic              zero,
    output logic              ovf
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        c;
    logic             adder_sub;
    logic [WIDTH-1:0] adder_sum;
    logic             adder_ovf;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;
    logic [SHW-1:0]   shift_amt;
    logic             less;

    assign c = alu_ctrl_t'(ctrl);

    // The compare class always subtracts, whatever the add/sub bit says.
    assign adder_sub = (c.cls != CLS_ARITH) | c.sub;
    assign shift_amt = c.sh.use_var ? op_b[SHW-1:0] : shamt;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (adder_sub),
        .sum (adder_sum),
        .ovf (adder_ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a  (op_a),
        .b  (op_b),
        .op (c.lop),
        .y  (logic_y)
    );

    alu_barrel #(.WIDTH(WIDTH)) u_barrel (
        .din       (op_a),
        .amt       (shift_amt),
        .dir_right (c.sh.dir_right),
        .arith     (c.sh.arith),
        .dout      (shift_y)
    );

    // Sign of the difference, corrected when the subtraction overflowed.
    assign less = adder_sum[MSB] ^ adder_ovf;

    always_comb begin
        unique case (c.cls)
            CLS_SHIFT: result = shift_y;
            CLS_SLT:   result = {{(WIDTH-1){1'b0}}, less};
            CLS_ARITH: result = adder_sum;
            default:   result = logic_y;
        endcase
    end

    assign zero = (result == '0);
    assign ovf  = (c.cls == CLS_ARITH) && adder_ovf;

    always_comb begin
        AST_SLT_ONE_BIT: assert (c.cls != CLS_SLT || result[MSB:1] == '0);                  // R7
        AST_SLT_SIGNS: assert (!(c.cls == CLS_SLT && op_a[MSB] && !op_b[MSB]) || result[0]); // R7
        AST_OVF_CLASS: assert (!ovf || c.cls == CLS_ARITH);                                   // R8
        AST_ZERO_FLAG: assert (!zero || !(|logic_y) || c.cls != CLS_LOGIC);                   // R9
    end

endmodule

// File: tb/alu_multifunc_test.sv
module alu_multifunc_test;

    localparam int  W        = 32;
    localparam int  SW       = 5;
    localparam time HALF     = 4ns;
    localparam int  WD_LIMIT = 100000;

    typedef struct {
        logic [W-1:0] res;
        logic         zf;
        logic         of;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [SW-1:0] shamt = '0;
    logic [7:0]    ctrl = 8'b1100_0000;
    logic [W-1:0]  result;
    logic          zero;
    logic          ovf;

    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    exp_t q[$];

    always #(HALF) clk = ~clk;

    alu_multifunc uut (
        .op_a   (op_a),
        .op_b   (op_b),
        .shamt  (shamt),
        .ctrl   (ctrl),
        .result (result),
        .zero   (zero),
        .ovf    (ovf)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [SW-1:0] k, input logic [7:0] c);
        exp_t e;
        logic [W:0]    wide;
        logic [SW-1:0] n;
        e.of = 1'b0;
        case (c[7:6])
            2'b00: begin
                n = c[2] ? b[SW-1:0] : k;
                if (!c[4]) begin
                    e.res = a << n;
                    e.tag = "R5";
                end else if (c[3]) begin
                    e.res = $signed(a) >>> n;
                    e.tag = "R6";
                end else begin
                    e.res = a >> n;
                    e.tag = "R6";
                end
            end
            2'b01: begin
                e.res = ($signed(a) < $signed(b)) ? 1 : 0;
                e.tag = "R7";
            end
            2'b10: begin
                if (c[5]) wide = {a[W-1], a} - {b[W-1], b};
                else      wide = {a[W-1], a} + {b[W-1], b};
                e.res = wide[W-1:0];
                e.of  = wide[W] != wide[W-1];
                e.tag = c[5] ? "R3" : "R2";
            end
            default: begin
                case (c[1:0])
                    2'b00:   e.res = a & b;
                    2'b01:   e.res = a | b;
                    2'b10:   e.res = a ^ b;
                    default: e.res = ~(a | b);
                endcase
                e.tag = "R4";
            end
        endcase
        e.zf = (e.res == '0);
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [SW-1:0] k, input logic [7:0] c);
        @(posedge clk);
        #1;
        op_a  = a;
        op_b  = b;
        shamt = k;
        ctrl  = c;
        q.push_back(model(a, b, k, c));
    endtask

    // Monitor: results are combinational, due in the cycle they are driven.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (result !== e.res) begin
                failures++;
                $display("FAIL %s,R1 result ctrl=%b actual=%h expected=%h", e.tag, ctrl, result, e.res);
            end
            checks++;
            if (zero !== e.zf) begin
                failures++;
                $display("FAIL R9 zero ctrl=%b actual=%b expected=%b", ctrl, zero, e.zf);
            end
            checks++;
            if (ovf !== e.of) begin
                failures++;
                $display("FAIL R8 ovf ctrl=%b actual=%b expected=%b", ctrl, ovf, e.of);
            end
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-state pattern: all-zero operands through AND (R4, R9)
        drive('0, '0, '0, 8'b11_0_000_00);
        // R2: add, with and without signed overflow (R8)
        drive(32'd5, 32'd7, '0, 8'b10_0_000_00);
        drive(32'h7FFF_FFFF, 32'd1, '0, 8'b10_0_000_00);
        drive(32'hFFFF_FFFF, 32'd1, '0, 8'b10_0_000_00);
        // R3: subtract, equal operands, overflow
        drive(32'h1234_5678, 32'h1234_5678, '0, 8'b10_1_000_00);
        drive(32'h8000_0000, 32'd1, '0, 8'b10_1_000_00);
        drive(32'd3, 32'd10, '0, 8'b10_1_000_00);
        // R7: signed compare incl. overflowing difference
        drive(32'hFFFF_FFFF, 32'd1, '0, 8'b01_0_000_00);
        drive(32'd1, 32'hFFFF_FFFF, '0, 8'b01_0_000_00);
        drive(32'h8000_0000, 32'h7FFF_FFFF, '0, 8'b01_0_000_00);
        drive(32'h7FFF_FFFF, 32'h8000_0000, '0, 8'b01_1_000_00);
        drive(32'd9, 32'd9, '0, 8'b01_0_000_00);
        // R4: every bitwise function
        for (int i = 0; i < 4; i++)
            drive(32'hF0F0_3C3C, 32'hFF00_0FF0, '0, {6'b11_0_000, 2'(i)});
        drive(32'hFFFF_0000, 32'h0000_FFFF, '0, 8'b11_0_000_11);
        // R5: left shifts, constant and variable amount, 0 and 31, arith bit ignored
        drive(32'hDEAD_BEEF, 32'd0, 5'd0, 8'b00_0_000_00);
        drive(32'hDEAD_BEEF, 32'd0, 5'd31, 8'b00_0_000_00);
        drive(32'h0000_0003, 32'hFFFF_FFE4, 5'd0, 8'b00_0_001_00);
        drive(32'h8000_0001, 32'd0, 5'd4, 8'b00_0_010_00);
        // R6: right shifts, logical and arithmetic, negative values, 0 and 31
        drive(32'h8000_0000, 32'd0, 5'd31, 8'b00_0_100_00);
        drive(32'h8000_0000, 32'd0, 5'd31, 8'b00_0_110_00);
        drive(32'hF000_0000, 32'h0000_0024, 5'd0, 8'b00_0_111_00);
        drive(32'h7000_0000, 32'h0000_0004, 5'd0, 8'b00_0_111_00);
        drive(32'h8765_4321, 32'd0, 5'd0, 8'b00_0_110_00);
        drive(32'h8765_4321, 32'd31, 5'd0, 8'b00_0_111_00);
        // R1: pseudo-random sweep over all classes and control words
        for (int i = 0; i < 2000; i++)
            drive($urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom,
                  SW'($urandom), 8'($urandom));
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule